// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts where a return instruction will jump. It holds a small stack of return addresses that follows the call and return nesting of the program. When a call is confirmed, its return address is pushed. When a return is confirmed, the stack is popped. The entry currently on top is always offered as the predicted return target, together with a flag that says whether the stack holds anything.

Both update events come from the pipeline point where branch outcomes have already been checked. Calls and returns on a wrong path therefore never reach the stack. The storage is circular. When more calls are pushed than the stack can hold, the oldest address is lost without warning. A push and a pop in the same cycle, which happens when a return is immediately followed by a call, replace the top entry in place.

Top module: `ras_predictor`

## Requirements
- R1: During and right after reset (synchronous, active-low `rst_n`), `top_valid_o` is 0 and `top_addr_o` is all zeros.
- R2: A push without a pop makes `top_addr_o` equal to the pushed address from the next cycle on, and `top_valid_o` becomes 1.
- R3: A pop without a push on a non-empty stack removes the top entry, so `top_addr_o` shows the address pushed before it (last-in, first-out order).
- R4: The occupancy saturates at DEPTH. After more than DEPTH pushes, the most recent DEPTH addresses come back in reverse order, and the stack is empty after exactly DEPTH pops.
- R5: A pop on an empty stack has no effect. The stack stays empty and invalid, and a later push yields a one-entry stack.
- R6: A push and a pop in the same cycle on a non-empty stack replace the top address with the pushed one. The depth stays the same and the entries below are untouched.
- R7: A push and a pop in the same cycle on an empty stack act as a push, leaving one valid entry.
- R8: Whenever `top_valid_o` is 0, `top_addr_o` is all zeros.
- R9: A cycle with neither push nor pop leaves the top address, the validity and the stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Confirmed call: push `push_addr_i` |
| push_addr_i | input | ADDR_W | Return address of the call |
| pop_i | input | 1 | Confirmed return: pop the top entry |
| top_addr_o | output | ADDR_W | Predicted return address (top of stack) |
| top_valid_o | output | 1 | Stack holds at least one entry |

## Verification
The bench builds the block with DEPTH set to 4 and ADDR_W set to 16. A shallow stack means random traffic wraps the pointer and saturates the occupancy many times. Overflow loss, wrap-around reads and pops after saturation all occur often, not only in a few hand-written sequences. The narrow address keeps the values readable while still telling entries apart.

// File: rtl/ras_pkg.sv
// Package: shared types for the return address stack.
// Assumes: the update decode is formed from {push, pop} in that bit order.
package ras_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_SWAP = 2'b11
    } ras_op_e;
endpackage

// File: rtl/ras_store.sv
// Module: address storage for the return stack.
// Purpose: DEPTH registers with one write port and one asynchronous read port.
// Assumes: indices are below DEPTH; the contents need no reset because the
// controller reports validity separately.
module ras_store #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data
);
    logic [ADDR_W-1:0] slot_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        // Capture the write data into this slot when it is addressed.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == PTR_W'(e))) begin
                slot_q[e] <= wr_data;
            end
        end
    end

    // Read the slot chosen by the pointer.
    always_comb begin
        rd_data = slot_q[rd_idx];
    end
endmodule

// File: rtl/ras_ctrl.sv
// Module: pointer and occupancy control for the return stack.
// Purpose: decodes push/pop, moves the circular top pointer, keeps a count
// that saturates at DEPTH, and selects the storage write slot.
// Assumes: push and pop come only from resolved (non-speculative) events.
module ras_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] top_idx,
    output logic             not_empty
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    ras_op_e          op;
    logic [PTR_W-1:0] ptr_q, ptr_d, ptr_up, ptr_dn;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Build the operation code from the two request lines.
    always_comb begin
        op = ras_op_e'({push, pop});
    end

    // Neighbour indices with wrap-around for any depth.
    always_comb begin
        ptr_up = (ptr_q == LAST_IDX) ? '0 : ptr_q + PTR_W'(1);
        ptr_dn = (ptr_q == '0) ? LAST_IDX : ptr_q - PTR_W'(1);
    end

    // Next pointer and occupancy for each operation.
    always_comb begin
        ptr_d = ptr_q;
        cnt_d = cnt_q;
        unique case (op)
            OP_PUSH: begin
                ptr_d = ptr_up;
                if (cnt_q != FULL_CNT) cnt_d = cnt_q + CNT_W'(1);
            end
            OP_POP: begin
                if (cnt_q != '0) begin
                    ptr_d = ptr_dn;
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            OP_SWAP: begin
                if (cnt_q == '0) cnt_d = CNT_W'(1);
            end
            default: ;
        endcase
    end

    // Register the pointer and occupancy, clearing both on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else begin
            ptr_q <= ptr_d;
            cnt_q <= cnt_d;
        end
    end

    // Write slot: a plain push goes above the top, a swap overwrites it.
    always_comb begin
        wr_en  = push && rst_n;
        wr_idx = (op == OP_PUSH) ? ptr_up : ptr_q;
    end

    // Present the top slot and the occupancy flag.
    always_comb begin
        top_idx   = ptr_q;
        not_empty = (cnt_q != '0);
    end

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

    assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && cnt_q != FULL_CNT) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    assert_full_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && cnt_q == FULL_CNT) |=> (cnt_q == FULL_CNT));

    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && cnt_q == '0) |=> (cnt_q == '0 && $stable(ptr_q)));

    assert_pop_shrinks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    assert_swap_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(ptr_q));

    assert_swap_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && cnt_q == '0) |=> (cnt_q == CNT_W'(1)));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> ($stable(ptr_q) && $stable(cnt_q)));
endmodule

// File: rtl/ras_predictor.sv
// Module: return address stack predictor (top level).
// Purpose: pushes confirmed call return addresses, pops on confirmed returns,
// and offers the top entry as the predicted return target.
// Assumes: updates arrive after misprediction checks; overflow drops the
// oldest entry silently; the output address reads zero when empty.
module ras_predictor #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              pop_i,
    output logic [ADDR_W-1:0] top_addr_o,
    output logic              top_valid_o
);
    logic              wr_en;
    logic [PTR_W-1:0]  wr_idx;
    logic [PTR_W-1:0]  top_idx;
    logic              not_empty;
    logic [ADDR_W-1:0] rd_data;

    ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_i),
        .pop       (pop_i),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .top_idx   (top_idx),
        .not_empty (not_empty)
    );

    ras_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (push_addr_i),
        .rd_idx  (top_idx),
        .rd_data (rd_data)
    );

    // Gate the predicted address with the occupancy flag.
    always_comb begin
        top_valid_o = not_empty;
        top_addr_o  = not_empty ? rd_data : '0;
    end

    assert_push_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (top_valid_o && top_addr_o == $past(push_addr_i)));

    assert_zero_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !top_valid_o |-> (top_addr_o == '0));

    assert_idle_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> ($stable(top_addr_o) && $stable(top_valid_o)));
endmodule

// File: tb/tb_ras_predictor.sv
module tb_ras_predictor;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_i = 1'b0;
    logic              pop_i = 1'b0;
    logic [ADDR_W-1:0] push_addr_i = '0;
    logic [ADDR_W-1:0] top_addr_o;
    logic              top_valid_o;

    int checks = 0;
    int fails  = 0;
    logic [ADDR_W-1:0] model[$];

    always #4 clk = ~clk;

    ras_predictor #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
        .pop_i(pop_i), .top_addr_o(top_addr_o), .top_valid_o(top_valid_o)
    );

    function automatic logic [ADDR_W-1:0] exp_top();
        return (model.size() != 0) ? model[model.size()-1] : '0;
    endfunction

    function automatic logic exp_valid();
        return model.size() != 0;
    endfunction

    task automatic check_out(string tag);
        checks++;
        if (top_valid_o !== exp_valid() || top_addr_o !== exp_top()) begin
            fails++;
            $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
                     tag, top_valid_o, top_addr_o, exp_valid(), exp_top());
        end
    endtask

    // Apply one cycle of stimulus, update the model, check after the edge.
    task automatic step(input logic ps, input logic pp, input logic [ADDR_W-1:0] a);
        string tag;
        @(negedge clk);
        push_i = ps; pop_i = pp; push_addr_i = a;
        @(posedge clk);
        #1;
        if (ps && pp) begin
            if (model.size() == 0) begin
                model.push_back(a); tag = "R7";
            end else begin
                model[model.size()-1] = a; tag = "R6";
            end
        end else if (ps) begin
            model.push_back(a);
            if (model.size() > DEPTH) begin
                void'(model.pop_front()); tag = "R4";
            end else tag = "R2";
        end else if (pp) begin
            if (model.size() == 0) tag = "R5";
            else begin
                void'(model.pop_back()); tag = "R3";
            end
        end else tag = "R9";
        if (!exp_valid() && tag != "R5") tag = {tag, "/R8"};
        check_out(tag);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state, sampled with reset still asserted and after release
        repeat (3) @(posedge clk);
        #1; check_out("R1");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1; check_out("R1");

        // R5: pops on empty, then a single push
        step(1'b0, 1'b1, '0);
        step(1'b0, 1'b1, '0);
        step(1'b1, 1'b0, 16'h1111);
        step(1'b0, 1'b1, '0);
        // R7: swap on empty acts as push
        step(1'b1, 1'b1, 16'h2222);
        step(1'b0, 1'b1, '0);
        // R4: overflow by three, then drain all plus one extra
        for (int i = 0; i < DEPTH + 3; i++) step(1'b1, 1'b0, ADDR_W'(16'hA000 + i));
        for (int i = 0; i < DEPTH + 1; i++) step(1'b0, 1'b1, '0);
        // R6: swap mid-stack keeps lower entries
        step(1'b1, 1'b0, 16'h0B01);
        step(1'b1, 1'b0, 16'h0B02);
        step(1'b1, 1'b1, 16'h0B99);
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b1, '0);
        step(1'b0, 1'b1, '0);

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            logic ps = (r < 45) || (r >= 90);
            logic pp = (r >= 45 && r < 80) || (r >= 90);
            step(ps, pp, ADDR_W'($urandom));
        end

        // R1: reset mid-run empties the stack
        @(negedge clk); rst_n = 1'b0; push_i = 1'b0; pop_i = 1'b0;
        @(posedge clk); #1;
        model.delete();
        check_out("R1");
        @(negedge clk); rst_n = 1'b1;
        step(1'b0, 1'b1, '0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule